// File: doc/BRIEF.md
# Even-Parity Generator and Checker with Fault Injection

This block is a combinational harness for exercising an even-parity scheme on a short data word. A parity generator computes one parity bit for the incoming word. A parity checker receives the generated parity bit together with a second copy of the word. In that copy, the lowest bits can each be replaced by a separately supplied fault value. When the two copies agree, the checker never raises its flag. When they differ in an odd number of positions, the flag rises. When they differ in an even number of positions, the fault passes unseen.

Both parity engines are ripple chains of two-input XOR stages. The checker chain starts from the incoming parity bit, and the generator chain starts from zero. The number of data bits and the number of injectable bits are parameters. A polarity parameter inverts every output at once, so the outputs can drive indicators that light on a low level. The block also brings out the data word and the checker-side word, so the effect of an injection can be observed. The block has no clock and no reset.

Top module: `parity_inject_harness`

## Requirements
- R1: `gen_par_o` is 1 exactly when `data_in` holds an odd number of ones, so the word plus the parity bit always holds an even count (active-high polarity).
- R2: Checker word bit j, for j below INJ_W (bits 0 and 1 by default), equals `inj_val[j]` when `inj_sel[j]` is 1 and `data_in[j]` when it is 0. Each select acts only on its own bit.
- R3: Checker word bits from INJ_W up to DATA_W-1 (bits 2 to 4 by default) always equal the same bits of `data_in`.
- R4: With `inj_sel` all zero, `chk_err_o` is 0 for every value of `data_in` and `inj_val`.
- R5: When exactly one checker word bit differs from `data_in`, `chk_err_o` is 1.
- R6: When two checker word bits differ from `data_in`, `chk_err_o` is 0, because an even number of faults goes undetected.
- R7: In general, `chk_err_o` equals the odd/even count of positions where the checker word and `data_in` differ. This includes selecting injection with a fault value equal to the data bit, which gives 0.
- R8: `data_echo_o` equals `data_in`, and `chk_word_o` carries the checker-side word.
- R9: With OUT_POL set to active-low, each of `gen_par_o`, `chk_err_o`, `data_echo_o` and `chk_word_o` is the bitwise inverse of its active-high value for the same inputs.
- R10: The outputs follow the inputs with no clock: new inputs produce settled outputs within the same time step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W (5) | Data word fed to the generator and to the checker path |
| inj_sel | input | INJ_W (2) | Per-bit fault select for the lowest checker bits |
| inj_val | input | INJ_W (2) | Fault values used where the matching select is 1 |
| gen_par_o | output | 1 | Generated even-parity bit |
| chk_err_o | output | 1 | Checker flag, raised on an odd number of mismatches |
| data_echo_o | output | DATA_W (5) | Copy of the data word |
| chk_word_o | output | DATA_W (5) | Word actually seen by the checker |

## Verification
The bound checks take for granted that every input carries a known 0 or 1, never X or Z. They also assume that the outputs are read only after the combinational chain has settled on a new input set. The stimulus meets both conditions. It drives every input to a defined value on each rising clock edge and holds it there. Outputs are compared only at the following falling edge, after the chains have settled. The stimulus sweeps every data word against every select and fault-value pair, on both an active-high and an active-low instance.

// File: rtl/parity_inject_pkg.sv
package parity_inject_pkg;

   // Output polarity choice for the harness pins
   typedef enum bit {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } out_pol_e;

   localparam int unsigned DEF_DATA_W = 5;
   localparam int unsigned DEF_INJ_W  = 2;

endpackage

// File: rtl/parity_xor_chain.sv
// Ripple XOR chain: stage k folds bit k into the running parity of stage k-1.
// The first stage folds in an external seed (0 for generation, parity for checking).
module parity_xor_chain #(
   parameter int unsigned WIDTH = 5
) (
   input  logic [WIDTH-1:0] bits_i,
   input  logic             seed_i,
   output logic             par_o
);

   logic [WIDTH-1:0] stage;

   assign stage[0] = bits_i[0] ^ seed_i;

   generate
      for (genvar k = 1; k < WIDTH; k++) begin : g_stage
         assign stage[k] = bits_i[k] ^ stage[k-1];
      end
   endgenerate

   assign par_o = stage[WIDTH-1];

endmodule

// File: rtl/parity_fault_mux.sv
// Builds the checker-side word: the lowest INJ_W bits may be replaced
// by fault values, the remainder pass straight through.
module parity_fault_mux #(
   parameter int unsigned WIDTH = 5,
   parameter int unsigned INJ_W = 2
) (
   input  logic [WIDTH-1:0] word_i,
   input  logic [INJ_W-1:0] sel_i,
   input  logic [INJ_W-1:0] val_i,
   output logic [WIDTH-1:0] word_o
);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         if (b < INJ_W) begin : g_sel
            assign word_o[b] = sel_i[b] ? val_i[b] : word_i[b];
         end else begin : g_pass
            assign word_o[b] = word_i[b];
         end
      end
   endgenerate

endmodule

// File: rtl/parity_out_pol.sv
// Applies the configured output polarity to a packed bundle of status bits.
module parity_out_pol
   import parity_inject_pkg::*;
#(
   parameter int unsigned WIDTH = 12,
   parameter out_pol_e    POL   = POL_ACT_HIGH
) (
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] pin_o
);

   generate
      if (POL == POL_ACT_LOW) begin : g_low
         assign pin_o = ~raw_i;
      end else begin : g_high
         assign pin_o = raw_i;
      end
   endgenerate

endmodule

// File: rtl/parity_inject_harness.sv
module parity_inject_harness
   import parity_inject_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned INJ_W   = DEF_INJ_W,
   parameter out_pol_e    OUT_POL = POL_ACT_HIGH
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [INJ_W-1:0]  inj_sel,
   input  logic [INJ_W-1:0]  inj_val,
   output logic              gen_par_o,
   output logic              chk_err_o,
   output logic [DATA_W-1:0] data_echo_o,
   output logic [DATA_W-1:0] chk_word_o
);

   localparam int unsigned BUNDLE_W = 2 * DATA_W + 2;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("parity_inject_harness: DATA_W must be at least 2");
      end
      if ((INJ_W < 1) || (INJ_W > DATA_W)) begin : g_bad_inj
         $error("parity_inject_harness: INJ_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0]   chk_word;
   logic                gen_par;
   logic                chk_err;
   logic [BUNDLE_W-1:0] raw_bundle;
   logic [BUNDLE_W-1:0] pin_bundle;

   // Generator: chain seeded with zero
   parity_xor_chain #(
      .WIDTH (DATA_W)
   ) gen_chain_i (
      .bits_i (data_in),
      .seed_i (1'b0),
      .par_o  (gen_par)
   );

   // Fault insertion on the checker path
   parity_fault_mux #(
      .WIDTH (DATA_W),
      .INJ_W (INJ_W)
   ) fault_mux_i (
      .word_i (data_in),
      .sel_i  (inj_sel),
      .val_i  (inj_val),
      .word_o (chk_word)
   );

   // Checker: chain seeded with the generated parity
   parity_xor_chain #(
      .WIDTH (DATA_W)
   ) chk_chain_i (
      .bits_i (chk_word),
      .seed_i (gen_par),
      .par_o  (chk_err)
   );

   assign raw_bundle = {chk_word, data_in, chk_err, gen_par};

   parity_out_pol #(
      .WIDTH (BUNDLE_W),
      .POL   (OUT_POL)
   ) out_pol_i (
      .raw_i (raw_bundle),
      .pin_o (pin_bundle)
   );

   assign gen_par_o   = pin_bundle[0];
   assign chk_err_o   = pin_bundle[1];
   assign data_echo_o = pin_bundle[DATA_W+1:2];
   assign chk_word_o  = pin_bundle[BUNDLE_W-1:DATA_W+2];

endmodule

// File: rtl/parity_inject_chk.sv
module parity_inject_chk
   import parity_inject_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned INJ_W   = DEF_INJ_W,
   parameter out_pol_e    OUT_POL = POL_ACT_HIGH
) (
   input logic [DATA_W-1:0] data_in,
   input logic [INJ_W-1:0]  inj_sel,
   input logic [INJ_W-1:0]  inj_val,
   input logic              gen_par_o,
   input logic              chk_err_o,
   input logic [DATA_W-1:0] data_echo_o,
   input logic [DATA_W-1:0] chk_word_o
);

   localparam bit INV = (OUT_POL == POL_ACT_LOW);

   logic              gen_r;
   logic              err_r;
   logic [DATA_W-1:0] echo_r;
   logic [DATA_W-1:0] word_r;

   always_comb begin
      gen_r  = gen_par_o ^ INV;
      err_r  = chk_err_o ^ INV;
      echo_r = data_echo_o ^ {DATA_W{INV}};
      word_r = chk_word_o ^ {DATA_W{INV}};

      // R1
      gen_parity_chk: assert (gen_r == $countones(data_in) % 2)
         else $error("generated parity wrong");

      for (int j = 0; j < DATA_W; j++) begin
         if (j < INJ_W) begin
            // R2
            inj_mux_chk: assert (word_r[j] == (inj_sel[j] ? inj_val[j] : data_in[j]))
               else $error("injected bit %0d wrong", j);
         end else begin
            // R3
            pass_bit_chk: assert (word_r[j] == data_in[j])
               else $error("pass-through bit %0d wrong", j);
         end
      end

      // R4
      no_inject_clean_chk: assert (!((inj_sel == '0) && err_r))
         else $error("flag raised without injection");

      // R7
      flag_matches_diff_chk: assert (err_r == ($countones(data_in ^ word_r) % 2))
         else $error("flag does not match mismatch count");

      // R8
      echo_chk: assert (echo_r == data_in)
         else $error("data echo wrong");
   end

endmodule

bind parity_inject_harness parity_inject_chk #(
   .DATA_W  (DATA_W),
   .INJ_W   (INJ_W),
   .OUT_POL (OUT_POL)
) chk_i (
   .data_in     (data_in),
   .inj_sel     (inj_sel),
   .inj_val     (inj_val),
   .gen_par_o   (gen_par_o),
   .chk_err_o   (chk_err_o),
   .data_echo_o (data_echo_o),
   .chk_word_o  (chk_word_o)
);

// File: tb/parity_inject_harness_tb_top.sv
`timescale 1ns/1ps
module parity_inject_harness_tb_top;
   import parity_inject_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [4:0] data_in = '0;
   logic [1:0] inj_sel = '0;
   logic [1:0] inj_val = '0;

   logic       gen_h, err_h, gen_l, err_l;
   logic [4:0] echo_h, word_h, echo_l, word_l;

   parity_inject_harness dut_i (
      .data_in     (data_in),
      .inj_sel     (inj_sel),
      .inj_val     (inj_val),
      .gen_par_o   (gen_h),
      .chk_err_o   (err_h),
      .data_echo_o (echo_h),
      .chk_word_o  (word_h)
   );

   parity_inject_harness #(.OUT_POL(POL_ACT_LOW)) dut_lo_i (
      .data_in     (data_in),
      .inj_sel     (inj_sel),
      .inj_val     (inj_val),
      .gen_par_o   (gen_l),
      .chk_err_o   (err_l),
      .data_echo_o (echo_l),
      .chk_word_o  (word_l)
   );

   typedef struct packed {
      logic [4:0] d;
      logic [1:0] s;
      logic       gen;
      logic       err;
      logic [4:0] word;
      int         ndiff;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: applies a vector and queues its expected result
   task automatic drive(input logic [4:0] d, input logic [1:0] s, input logic [1:0] v);
      exp_t e;
      int   ones;
      @(posedge clk);
      data_in = d;
      inj_sel = s;
      inj_val = v;
      ones = 0;
      for (int b = 0; b < 5; b++) if (d[b]) ones++;
      e.d   = d;
      e.s   = s;
      e.gen = (ones % 2 == 1);
      for (int b = 0; b < 5; b++) e.word[b] = (b < 2 && s[b]) ? v[b] : d[b];
      e.ndiff = 0;
      for (int b = 0; b < 5; b++) if (e.word[b] != d[b]) e.ndiff++;
      e.err = (e.ndiff % 2 == 1);
      q.push_back(e);
   endtask

   // Monitor: compares at the falling edge after each vector
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t  e;
            string ftag;
            e = q.pop_front();
            // R1 / R10: settled within the same cycle, no clock inside the block
            chk(gen_h == e.gen, "R1 gen parity", 32'(gen_h), 32'(e.gen));
            // R2 injected bits, R3 pass-through bits
            chk(word_h[1:0] == e.word[1:0], "R2 injected bits", 32'(word_h[1:0]), 32'(e.word[1:0]));
            chk(word_h[4:2] == e.d[4:2], "R3 pass-through bits", 32'(word_h[4:2]), 32'(e.d[4:2]));
            if (e.s == 2'b00)        ftag = "R4 flag with no injection";
            else if (e.ndiff == 1)   ftag = "R5 flag single fault";
            else if (e.ndiff == 2)   ftag = "R6 flag double fault";
            else                     ftag = "R7 flag matching fault value";
            chk(err_h == e.err, ftag, 32'(err_h), 32'(e.err));
            // R8
            chk(echo_h == e.d, "R8 data echo", 32'(echo_h), 32'(e.d));
            // R9 active-low instance
            chk({gen_l, err_l, echo_l, word_l} == ~{e.gen, e.err, e.d, e.word},
                "R9 active-low outputs", 32'({gen_l, err_l, echo_l, word_l}),
                32'(~{e.gen, e.err, e.d, e.word}));
         end
      end
   end

   initial begin
      // Initial all-zero vector stands in for the idle state
      drive(5'd0, 2'b00, 2'b00);
      for (int d = 0; d < 32; d++)
         for (int s = 0; s < 4; s++)
            for (int v = 0; v < 4; v++)
               drive(5'(d), 2'(s), 2'(v));
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R10 actual=hung expected=complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule